// File: doc/BRIEF.md
# Microprocessor Bus Read Responder

This block answers read cycles on an 8-bit microprocessor bus that has an enable strobe, a read/write line and a single 8-bit pin group. Three external buffers share that pin group: one passes address bits A7..A0, one passes A14..A8, and one passes data. A 3-bit active-low select code picks which buffer is active. For each read cycle the block collects the 15-bit bus address in two steps by switching the select. It joins the address with a host-loaded base page to form a 32-bit lookup word and sends that word out on a valid/ready request port. It then waits for a byte on a response port and drives that byte onto the pin group until the strobe falls. After a short hold it releases the pins.

The controller is a single enumerated state machine with these states and transitions:
- `ST_SEEK_LOW` moves to `ST_SEEK_RISE` when the strobe is low.
- `ST_SEEK_RISE` goes to `ST_SETTLE_LO` on a rising strobe with read/write high, or to `ST_WR_SKIP` on a rising strobe with read/write low.
- `ST_WR_SKIP` returns to `ST_SEEK_RISE` when the strobe falls.
- `ST_SETTLE_LO` leads to `ST_SETTLE_HI`, which leads to `ST_REQ`. Each of these two settle states captures one address half as it exits.
- `ST_REQ` moves to `ST_WAIT_RSP` when the request is accepted.
- `ST_WAIT_RSP` moves to `ST_DRIVE` when the response arrives.
- `ST_DRIVE` moves to `ST_HOLD` when the strobe falls.
- `ST_HOLD` moves to `ST_SEEK_LOW` after its hold count.
- The abort transition applies to `ST_SETTLE_LO`, `ST_SETTLE_HI`, `ST_REQ` and `ST_WAIT_RSP`. If the strobe falls in any of them, the machine jumps to `ST_SEEK_RISE` and raises an error pulse.

The bus strobe and read/write inputs are assumed to be synchronous to `clk`.

Top module: `mpu_read_responder`

## Requirements
- R1: The buffer select is active-low. `011` enables the address-low buffer, `101` the address-high buffer and `110` the data buffer; `111` would enable none. The block only ever outputs one of `011`, `101` or `110`.
- R2: A cycle is recognised only after the strobe has been seen low and then high. If the strobe is already high when reset is released, that is not a cycle. While waiting for a cycle the select is `011` and no request is made.
- R3: A cycle whose read/write line is 0 when the strobe rise is sampled is a write. On a write the block makes no request, never drives the pins and keeps the select at `011` until the strobe falls.
- R4: On a read, the select stays `011` for SETTLE_LO cycles after the rising strobe is sampled, and the pin value is then captured as A7..A0. The select then stays `101` for SETTLE_HI cycles, and pin bits 6:0 are then captured as A14..A8. Pin bit 7 is ignored in this capture.
- R5: The request word is {base_page[16:0], A14..A8, A7..A0}, with bits 31:15 taken from the base page. The request valid stays high, with the word unchanged, until ready is seen.
- R6: After a request is accepted the block waits any number of cycles for the response while the strobe stays high.
- R7: In the cycle after the response is accepted, the select is `110`, pad_out equals the returned byte and all eight output enables are 1.
- R8: Driving continues until the strobe is sampled low. It then lasts exactly HOLD_CYC more cycles, after which the output enables are 0 and the select is `011`.
- R9: If the strobe falls during the settle, request or response-wait states, the block never drives the pins. It raises cyc_abort for exactly one cycle and ignores any response that arrives later.
- R10: After reset the select is `011`, the output enables are 0, the request valid is 0 and cyc_abort is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Bus enable strobe, synchronous to clk |
| bus_rnw | input | 1 | Read/write line, 1 = read |
| pad_in | input | 8 | Value on the shared pin group |
| pad_out | output | 8 | Data driven onto the pin group |
| pad_oe | output | 8 | Per-pin output enable |
| buf_sel_n | output | 3 | Active-low buffer select |
| base_page | input | 17 | Host-loaded upper bits of the lookup word |
| lk_req_valid | output | 1 | Lookup request valid |
| lk_req_ready | input | 1 | Lookup request accepted |
| lk_req_addr | output | 32 | Lookup word |
| lk_rsp_valid | input | 1 | Lookup response valid |
| lk_rsp_data | input | 8 | Returned byte |
| cyc_abort | output | 1 | One-cycle pulse when a read is abandoned |

## Verification
Some rules are checked by assertions on every cycle:
- The select code is always a legal one.
- Output enables are raised only with the data select, and only just after a response.
- Output enables are released only together with the address-low select.
- A pending request stays stable while the strobe is high.
- The abort pulse lasts one cycle, follows a low strobe and never coincides with driving.

Other behaviours can only be shown by the bench's cycle scenarios:
- The exact settle and hold lengths.
- The assembled lookup word, including the ignored pin bit 7.
- Write cycles that cause no activity.
- The need to see the strobe low before the first cycle.
- Late responses after an abort that have no effect.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

    typedef enum logic [3:0] {
        ST_SEEK_LOW,
        ST_SEEK_RISE,
        ST_WR_SKIP,
        ST_SETTLE_LO,
        ST_SETTLE_HI,
        ST_REQ,
        ST_WAIT_RSP,
        ST_DRIVE,
        ST_HOLD
    } rdr_state_e;

    // active-low buffer select codes
    localparam logic [2:0] SEL_ADDR_LO = 3'b011;
    localparam logic [2:0] SEL_ADDR_HI = 3'b101;
    localparam logic [2:0] SEL_DATA    = 3'b110;

endpackage

// File: rtl/rdr_tick_cnt.sv
module rdr_tick_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rdr_capture.sv
module rdr_capture #(
    parameter int PIN_W     = 8,
    parameter int ADDR_HI_W = 7,
    parameter int LOOK_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cap_lo,
    input  logic                              cap_hi,
    input  logic                              cap_dat,
    input  logic [PIN_W-1:0]                  pad_in,
    input  logic [PIN_W-1:0]                  rsp_data,
    input  logic [LOOK_W-PIN_W-ADDR_HI_W-1:0] base_page,
    output logic [LOOK_W-1:0]                 look_word,
    output logic [PIN_W-1:0]                  drv_byte
);

    logic [PIN_W-1:0]     addr_lo_q;
    logic [ADDR_HI_W-1:0] addr_hi_q;
    logic [PIN_W-1:0]     data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            data_q    <= '0;
        end else begin
            if (cap_lo)  addr_lo_q <= pad_in;
            if (cap_hi)  addr_hi_q <= pad_in[ADDR_HI_W-1:0];
            if (cap_dat) data_q    <= rsp_data;
        end
    end

    assign look_word = {base_page, addr_hi_q, addr_lo_q};
    assign drv_byte  = data_q;

endmodule

// File: rtl/rdr_ctrl.sv
module rdr_ctrl
    import rdr_pkg::*;
#(
    parameter int SETTLE_LO = 4,
    parameter int SETTLE_HI = 6,
    parameter int HOLD_CYC  = 6,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_e,
    input  logic          bus_rnw,
    input  logic          req_ready,
    input  logic          rsp_valid,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cap_lo,
    output logic          cap_hi,
    output logic          cap_dat,
    output logic [2:0]    sel_n,
    output logic          drive,
    output logic          req_valid,
    output logic          abort_pulse
);

    localparam logic [CW-1:0] LO_LAST   = CW'(SETTLE_LO - 1);
    localparam logic [CW-1:0] HI_LAST   = CW'(SETTLE_HI - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

    rdr_state_e st_q, st_nxt;
    logic       abort;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_SEEK_LOW;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next state and capture strobes
    always_comb begin
        st_nxt  = st_q;
        cap_lo  = 1'b0;
        cap_hi  = 1'b0;
        cap_dat = 1'b0;
        abort   = 1'b0;
        unique case (st_q)
            ST_SEEK_LOW: begin
                if (!bus_e) st_nxt = ST_SEEK_RISE;
            end
            ST_SEEK_RISE: begin
                if (bus_e) st_nxt = bus_rnw ? ST_SETTLE_LO : ST_WR_SKIP;
            end
            ST_WR_SKIP: begin
                if (!bus_e) st_nxt = ST_SEEK_RISE;
            end
            ST_SETTLE_LO: begin
                if (!bus_e) begin
                    abort = 1'b1;
                end else if (cnt == LO_LAST) begin
                    cap_lo = 1'b1;
                    st_nxt = ST_SETTLE_HI;
                end
            end
            ST_SETTLE_HI: begin
                if (!bus_e) begin
                    abort = 1'b1;
                end else if (cnt == HI_LAST) begin
                    cap_hi = 1'b1;
                    st_nxt = ST_REQ;
                end
            end
            ST_REQ: begin
                if (!bus_e) begin
                    abort = 1'b1;
                end else if (req_ready) begin
                    st_nxt = ST_WAIT_RSP;
                end
            end
            ST_WAIT_RSP: begin
                if (!bus_e) begin
                    abort = 1'b1;
                end else if (rsp_valid) begin
                    cap_dat = 1'b1;
                    st_nxt  = ST_DRIVE;
                end
            end
            ST_DRIVE: begin
                if (!bus_e) st_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (cnt == HOLD_LAST) st_nxt = ST_SEEK_LOW;
            end
            default: st_nxt = ST_SEEK_LOW;
        endcase
        if (abort) st_nxt = ST_SEEK_RISE;
    end

    assign cnt_clr = (st_nxt != st_q);

    // Moore outputs
    always_comb begin
        sel_n     = SEL_ADDR_LO;
        drive     = 1'b0;
        req_valid = 1'b0;
        unique case (st_q)
            ST_SETTLE_HI, ST_WAIT_RSP: begin
                sel_n = SEL_ADDR_HI;
            end
            ST_REQ: begin
                sel_n     = SEL_ADDR_HI;
                req_valid = 1'b1;
            end
            ST_DRIVE, ST_HOLD: begin
                sel_n = SEL_DATA;
                drive = 1'b1;
            end
            default: begin
                sel_n = SEL_ADDR_LO;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_pulse <= 1'b0;
        end else begin
            abort_pulse <= abort;
        end
    end

endmodule

// File: rtl/mpu_read_responder.sv
module mpu_read_responder #(
    parameter int PIN_W     = 8,
    parameter int ADDR_HI_W = 7,
    parameter int LOOK_W    = 32,
    parameter int SETTLE_LO = 4,
    parameter int SETTLE_HI = 6,
    parameter int HOLD_CYC  = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_e,
    input  logic                              bus_rnw,
    input  logic [PIN_W-1:0]                  pad_in,
    output logic [PIN_W-1:0]                  pad_out,
    output logic [PIN_W-1:0]                  pad_oe,
    output logic [2:0]                        buf_sel_n,
    input  logic [LOOK_W-PIN_W-ADDR_HI_W-1:0] base_page,
    output logic                              lk_req_valid,
    input  logic                              lk_req_ready,
    output logic [LOOK_W-1:0]                 lk_req_addr,
    input  logic                              lk_rsp_valid,
    input  logic [PIN_W-1:0]                  lk_rsp_data,
    output logic                              cyc_abort
);

    localparam int MAX_LH  = (SETTLE_LO > SETTLE_HI) ? SETTLE_LO : SETTLE_HI;
    localparam int CNT_MAX = (MAX_LH > HOLD_CYC) ? MAX_LH : HOLD_CYC;
    localparam int CW      = $clog2(CNT_MAX) + 1;

    logic [CW-1:0] cnt;
    logic          cnt_clr;
    logic          cap_lo, cap_hi, cap_dat;
    logic          drive;

    rdr_tick_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    rdr_ctrl #(
        .SETTLE_LO (SETTLE_LO),
        .SETTLE_HI (SETTLE_HI),
        .HOLD_CYC  (HOLD_CYC),
        .CW        (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_e       (bus_e),
        .bus_rnw     (bus_rnw),
        .req_ready   (lk_req_ready),
        .rsp_valid   (lk_rsp_valid),
        .cnt         (cnt),
        .cnt_clr     (cnt_clr),
        .cap_lo      (cap_lo),
        .cap_hi      (cap_hi),
        .cap_dat     (cap_dat),
        .sel_n       (buf_sel_n),
        .drive       (drive),
        .req_valid   (lk_req_valid),
        .abort_pulse (cyc_abort)
    );

    rdr_capture #(
        .PIN_W     (PIN_W),
        .ADDR_HI_W (ADDR_HI_W),
        .LOOK_W    (LOOK_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .cap_dat   (cap_dat),
        .pad_in    (pad_in),
        .rsp_data  (lk_rsp_data),
        .base_page (base_page),
        .look_word (lk_req_addr),
        .drv_byte  (pad_out)
    );

    // one enable per pin, all following the drive state
    for (genvar gi = 0; gi < PIN_W; gi++) begin : g_oe
        assign pad_oe[gi] = drive;
    end

endmodule

// File: rtl/rdr_checker.sv
module rdr_checker
    import rdr_pkg::*;
#(
    parameter int PIN_W  = 8,
    parameter int LOOK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_e,
    input logic [2:0]        buf_sel_n,
    input logic [PIN_W-1:0]  pad_oe,
    input logic              lk_req_valid,
    input logic              lk_req_ready,
    input logic [LOOK_W-1:0] lk_req_addr,
    input logic              lk_rsp_valid,
    input logic              cyc_abort
);

    assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_sel_n == SEL_ADDR_LO) || (buf_sel_n == SEL_ADDR_HI) || (buf_sel_n == SEL_DATA));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req_valid && !lk_req_ready && bus_e) |=> (lk_req_valid && $stable(lk_req_addr)));

    assert_oe_with_data_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pad_oe) |-> (buf_sel_n == SEL_DATA));

    assert_drive_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe[0]) |-> $past(lk_rsp_valid));

    assert_release_to_addr_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_oe[0]) |-> (buf_sel_n == SEL_ADDR_LO));

    assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_abort |=> !cyc_abort);

    assert_abort_after_e_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_abort |-> !$past(bus_e));

    assert_abort_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_abort |-> !(|pad_oe));

endmodule

bind mpu_read_responder rdr_checker #(.PIN_W(PIN_W), .LOOK_W(LOOK_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_e        (bus_e),
    .buf_sel_n    (buf_sel_n),
    .pad_oe       (pad_oe),
    .lk_req_valid (lk_req_valid),
    .lk_req_ready (lk_req_ready),
    .lk_req_addr  (lk_req_addr),
    .lk_rsp_valid (lk_rsp_valid),
    .cyc_abort    (cyc_abort)
);

// File: tb/mpu_read_responder_tb_top.sv
module mpu_read_responder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LO   = 4;
    localparam int HI   = 6;
    localparam int HOLD = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_e = 1'b0;
    logic        bus_rnw = 1'b1;
    logic [7:0]  pad_in;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;
    logic [2:0]  buf_sel_n;
    logic [16:0] base_page = '0;
    logic        lk_req_valid;
    logic        lk_req_ready = 1'b0;
    logic [31:0] lk_req_addr;
    logic        lk_rsp_valid = 1'b0;
    logic [7:0]  lk_rsp_data = '0;
    logic        cyc_abort;

    logic [14:0] cur_addr = '0;
    logic        pad7 = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model of the three external buffers
    assign pad_in = (buf_sel_n == 3'b011) ? cur_addr[7:0] :
                    (buf_sel_n == 3'b101) ? {pad7, cur_addr[14:8]} : 8'hA5;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_read_responder dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_e        (bus_e),
        .bus_rnw      (bus_rnw),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .buf_sel_n    (buf_sel_n),
        .base_page    (base_page),
        .lk_req_valid (lk_req_valid),
        .lk_req_ready (lk_req_ready),
        .lk_req_addr  (lk_req_addr),
        .lk_rsp_valid (lk_rsp_valid),
        .lk_rsp_data  (lk_rsp_data),
        .cyc_abort    (cyc_abort)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [16:0] b, input logic [14:0] a);
        return {b, a[14:8], a[7:0]};
    endfunction

    // one bus cycle; abort_at > 0 drops the strobe at that iteration
    task automatic run_cycle(input bit rd, input logic [14:0] a, input logic [16:0] b,
                             input int rdy_lat, input int rsp_lat, input logic [7:0] dbyte,
                             input int abort_at);
        int cnt_lo = 0, cnt_hi = 0, oe_after = 0, n_err = 0, drv_age = 0, post = 0;
        int wait_rdy = 0, rsp_t = 0;
        bit seen_hi = 0, seen_req = 0, accepted = 0, rsp_done = 0, seen_drv = 0;
        bit efall = 0, any_req = 0, any_oe = 0, bad_sel = 0, finished = 0;
        logic [31:0] got_addr = '0;
        bus_e = 1'b0;
        repeat (2) @(negedge clk);
        cur_addr = a;
        base_page = b;
        pad7 = 1'($urandom);
        bus_rnw = rd;
        bus_e = 1'b1;
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            if (cyc_abort) n_err++;
            if (lk_req_valid) any_req = 1;
            if (pad_oe != 8'h00) any_oe = 1;
            if (buf_sel_n != 3'b011 && buf_sel_n != 3'b101 && buf_sel_n != 3'b110) bad_sel = 1;
            if (!rd && buf_sel_n != 3'b011) bad_sel = 1;
            if (!efall) begin
                if (!seen_hi) begin
                    if (buf_sel_n == 3'b011) cnt_lo++;
                    else if (buf_sel_n == 3'b101) seen_hi = 1;
                end
                if (seen_hi && !seen_req && buf_sel_n == 3'b101 && !lk_req_valid) cnt_hi++;
            end
            // request port responder
            if (lk_req_ready) begin
                lk_req_ready = 1'b0;
                accepted = 1;
            end else if (lk_req_valid && !accepted) begin
                if (!seen_req) begin
                    seen_req = 1;
                    got_addr = lk_req_addr;
                end
                if (wait_rdy >= rdy_lat) lk_req_ready = 1'b1;
                else wait_rdy++;
            end
            // response port
            if (lk_rsp_valid) begin
                lk_rsp_valid = 1'b0;
                rsp_done = 1;
            end else if (accepted && !rsp_done) begin
                if (rsp_t >= rsp_lat) begin
                    lk_rsp_valid = 1'b1;
                    lk_rsp_data = dbyte;
                end else begin
                    rsp_t++;
                end
            end
            // first driving cycle
            if (pad_oe != 8'h00 && !seen_drv) begin
                seen_drv = 1;
                check(buf_sel_n == 3'b110, "R7", "select while driving", 32'(buf_sel_n), 32'h6);
                check(pad_out == dbyte, "R7", "driven byte", 32'(pad_out), 32'(dbyte));
                check(pad_oe == 8'hFF, "R7", "output enables", 32'(pad_oe), 32'hFF);
            end
            // strobe control
            if (efall) begin
                if (pad_oe != 8'h00) oe_after++;
                post++;
            end else if (seen_drv) begin
                drv_age++;
                if (drv_age >= 2) begin
                    bus_e = 1'b0;
                    efall = 1;
                end
            end else if (abort_at > 0 && it + 1 >= abort_at) begin
                bus_e = 1'b0;
                efall = 1;
            end else if (!rd && it >= 8) begin
                bus_e = 1'b0;
                efall = 1;
            end
            if (efall && post >= ((abort_at > 0) ? 60 : HOLD + 4)) begin
                finished = 1;
                break;
            end
        end
        check(finished, "R6", "cycle completed", 32'(finished), 32'h1);
        check(!bad_sel, "R1", "select code legal", 32'(bad_sel), 32'h0);
        if (!rd) begin
            check(!any_req, "R3", "no request on write", 32'(any_req), 32'h0);
            check(!any_oe, "R3", "no drive on write", 32'(any_oe), 32'h0);
        end else if (abort_at > 0) begin
            check(n_err == 1, "R9", "abort pulse count", 32'(n_err), 32'h1);
            check(!any_oe, "R9", "no drive after abort", 32'(any_oe), 32'h0);
            check(buf_sel_n == 3'b011, "R9", "select after abort", 32'(buf_sel_n), 32'h3);
        end else begin
            check(cnt_lo == LO, "R4", "address-low settle cycles", 32'(cnt_lo), 32'(LO));
            check(cnt_hi == HI, "R4", "address-high settle cycles", 32'(cnt_hi), 32'(HI));
            check(got_addr == exp_word(b, a), "R5", "lookup word", got_addr, exp_word(b, a));
            check(oe_after == HOLD, "R8", "drive cycles after strobe low", 32'(oe_after), 32'(HOLD));
            check(pad_oe == 8'h00 && buf_sel_n == 3'b011, "R8", "released state",
                  {21'd0, buf_sel_n, pad_oe}, 32'h300);
            check(n_err == 0, "R9", "no abort on complete read", 32'(n_err), 32'h0);
        end
    endtask

    initial begin
        void'($urandom(32'd7091));
        // strobe high through reset
        bus_e = 1'b1;
        bus_rnw = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(buf_sel_n == 3'b011 && pad_oe == 8'h00 && !lk_req_valid && !cyc_abort,
              "R10", "reset state", {20'd0, cyc_abort, lk_req_valid, buf_sel_n, pad_oe[5:0]}, 32'h0C0);
        begin
            bit stray = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (buf_sel_n != 3'b011 || lk_req_valid) stray = 1;
            end
            check(!stray, "R2", "strobe high from reset ignored", 32'(stray), 32'h0);
        end
        // directed: normal reads, a long response wait, write, two aborts
        run_cycle(1'b1, 15'h1234, 17'h0_1ABC, 0, 0, 8'h3C, 0);
        run_cycle(1'b1, 15'h7FFF, 17'h1_FFFF, 3, 40, 8'hFF, 0);   // R6 long wait
        run_cycle(1'b1, 15'h0000, 17'h0_0000, 1, 2, 8'h00, 0);
        run_cycle(1'b0, 15'h2222, 17'h0_0001, 0, 0, 8'h11, 0);    // R3 write
        run_cycle(1'b1, 15'h4567, 17'h0_0F0F, 1, 30, 8'h77, LO + HI + 6); // R9 late response
        run_cycle(1'b1, 15'h0101, 17'h0_0002, 0, 0, 8'h22, 2);    // R9 abort in settle
        run_cycle(1'b1, 15'h5A5A, 17'h1_2345, 2, 1, 8'hC3, 0);    // recovers after aborts
        // constrained random cycles
        for (int n = 0; n < 24; n++) begin
            bit rd = (($urandom % 4) != 0);
            run_cycle(rd, 15'($urandom), 17'($urandom), int'($urandom % 4),
                      int'($urandom % 8), 8'($urandom), 0);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule